// File: doc/BRIEF.md
# Write-Only I2C Configuration Slave

This block is an I2C target that can only be written. It fills a small bank of 8-bit configuration registers from a two-wire bus. A free-running system clock, much faster than SCL, samples SCL and SDA. Both lines pass through a synchronizer before START, STOP and SCL edges are detected. The block answers one fixed 7-bit address, and only with the write direction bit. It acknowledges by pulling SDA low through an open-drain enable.

After the address, every transfer carries two bytes whose content does not matter. Both are acknowledged and then thrown away. The bytes that follow are stored into register 0, then register 1, and so on, until STOP. The block also acknowledges bytes past the last register, but it does not store them. All register contents are presented side by side on one output vector, which clock-generation logic uses directly. The only way to return the registers to their power-up values is the reset.

Top module: `cfg_i2c_wslave`

## Requirements
- R1: While reset is high and after it is released, `cfg_o` holds the power-up values. Register k sits at `cfg_o[8k+7:8k]`. Register 0 = 8'hF0. In register 0, bits 7:4 are frequency-select bits (all 1), bit 3 = 0 selects hardware frequency selection, and bits 1:0 are the output mode (00 normal, 01 wide spread, 10 narrow spread, 11 all outputs high impedance). Registers 1 to 6 = 8'hEF, 8'h7F, 8'hFF, 8'h0F, 8'h13, 8'h00.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A START, including a repeated START in the middle of a transfer, always begins a new address phase, so data then goes again to register 0.
- R3: The first byte after START is received MSB first. If it equals 8'hD2 (address 7'b1101001 with write bit 0), the block acknowledges it. An acknowledge is `sda_oe` = 1 (SDA pulled low) during the ninth SCL high phase.
- R4: The two bytes after a matched address are acknowledged whatever their value, and they change no register.
- R5: Every later byte is acknowledged and written into register 0, 1, 2, … in arrival order. Registers not reached before STOP keep their previous values.
- R6: If the address byte is anything other than 8'hD2, including 8'hD3 (read bit set), the block gives no acknowledge and neither acknowledges nor stores anything until the next START.
- R7: Data bytes beyond register 6 are acknowledged and discarded. Registers 0 to 6 keep the first seven data bytes.
- R8: `sda_oe` changes only while SCL is low, so it never makes a START or STOP on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling SCL |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| cfg_o | output | NUM_REGS*8 | All registers side by side, register k at bits 8k+7:8k |

## Verification
The bench drives the bus as an open-drain master. It runs a full seven-byte write, a short two-byte write, a transfer that holds only the two don't-care bytes, and a nine-byte overrun. Comparing these shows how ordered writes, retained registers, skipped bytes and discarded excess bytes each behave. A wrong address and a read-direction address show that the block stays silent and leaves the registers untouched. A repeated START in the middle of a transfer shows that writing starts again at register 0. A second reset pulse shows the defaults come back, and sampling SDA twice in each acknowledge high phase shows the drive is stable while SCL is high.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SKIP,
    ST_DATA,
    ST_IGNORE
  } slv_state_t;

  // Power-up contents of each configuration register
  function automatic logic [7:0] cfg_default(input int idx);
    case (idx)
      0:       return 8'hF0;
      1:       return 8'hEF;
      2:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'h0F;
      5:       return 8'h13;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] pipe [STAGES];
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
      prev <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~prev;
  assign fall = ~pipe[STAGES-1] & prev;

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'b1101001,
  parameter int         SKIP_BYTES = 2,
  parameter int         NUM_REGS   = 7,
  localparam int        PTR_W      = $clog2(NUM_REGS + 1),
  localparam int        SKIP_W     = $clog2(SKIP_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);

  localparam logic [7:0]       ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [PTR_W-1:0] PTR_END   = PTR_W'(NUM_REGS);

  slv_state_t        state;
  logic [7:0]        shreg;
  logic [3:0]        bitcnt;
  logic              ack_ph;
  logic [SKIP_W-1:0] skip_cnt;
  logic [PTR_W-1:0]  ptr;
  logic              active;
  logic              byte_done;

  assign active    = (state == ST_ADDR) || (state == ST_SKIP) || (state == ST_DATA);
  assign byte_done = active && scl_fall && !ack_ph && (bitcnt == 4'd8);

  assign wr_en   = byte_done && (state == ST_DATA) && (ptr < PTR_END);
  assign wr_idx  = ptr;
  assign wr_data = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      ack_ph   <= 1'b0;
      sda_oe   <= 1'b0;
      skip_cnt <= '0;
      ptr      <= '0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (active) begin
      if (scl_rise && !ack_ph) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall && ack_ph) begin
        sda_oe <= 1'b0;
        ack_ph <= 1'b0;
        bitcnt <= '0;
      end else if (byte_done) begin
        case (state)
          ST_ADDR: begin
            if (shreg == ADDR_BYTE) begin
              state    <= ST_SKIP;
              skip_cnt <= '0;
              ack_ph   <= 1'b1;
              sda_oe   <= 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_SKIP: begin
            ack_ph <= 1'b1;
            sda_oe <= 1'b1;
            if (skip_cnt == SKIP_W'(SKIP_BYTES - 1)) begin
              state <= ST_DATA;
              ptr   <= '0;
            end else begin
              skip_cnt <= skip_cnt + SKIP_W'(1);
            end
          end
          default: begin
            ack_ph <= 1'b1;
            sda_oe <= 1'b1;
            if (ptr != PTR_END) ptr <= ptr + PTR_W'(1);
          end
        endcase
      end
    end
  end

  // R2: a START always opens a fresh address phase
  a_r2_start_to_addr: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR) && (bitcnt == 4'd0));

  // R6: an unaddressed transfer never drives SDA
  a_r6_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe);

  // R8: SDA drive is held steady across an SCL high phase
  a_r8_oe_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfgslv_pkg::*;
#(
  parameter int  NUM_REGS = 7,
  localparam int PTR_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  logic [NUM_REGS*8-1:0] dflt;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign dflt[8*g +: 8] = cfg_default(g);
    always_ff @(posedge clk) begin
      if (rst)                                         cfg_o[8*g +: 8] <= cfg_default(g);
      else if (wr_en && (wr_idx == PTR_W'(g)))         cfg_o[8*g +: 8] <= wr_data;
    end
  end

  // R1: after reset the bank shows the power-up values
  a_r1_defaults_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_o == dflt));

  // R7: the writer never addresses a register past the bank
  a_r7_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < PTR_W'(NUM_REGS)));

endmodule

// File: rtl/cfg_i2c_wslave.sv
module cfg_i2c_wslave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1101001,
  parameter int         SKIP_BYTES  = 2,
  parameter int         NUM_REGS    = 7,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  logic [1:0]       lvl, rise, fall;
  logic             start_det, stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  // bit 1 = SCL, bit 0 = SDA
  i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_i, sda_i}),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  assign start_det = lvl[1] && fall[0];
  assign stop_det  = lvl[1] && rise[0];

  i2c_wr_fsm #(
    .DEV_ADDR   (DEV_ADDR),
    .SKIP_BYTES (SKIP_BYTES),
    .NUM_REGS   (NUM_REGS)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (lvl[1]),
    .sda_s     (lvl[0]),
    .scl_rise  (rise[1]),
    .scl_fall  (fall[1]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cfg_o   (cfg_o)
  );

endmodule

// File: tb/test_cfg_i2c_wslave.sv
module test_cfg_i2c_wslave;

  localparam int CLK_P = 10;
  localparam int Q     = 20;
  localparam int NR    = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl = 1'b1;
  logic          sda_m = 1'b1;
  logic          sda_oe;
  logic          sda_line;
  logic [NR*8-1:0] cfg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] tx   [16];
  logic       acks [16];
  logic       glitch;
  logic [7:0] exp_r [NR];

  always #(CLK_P/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  cfg_i2c_wslave i_cfg_i2c_wslave (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .cfg_o  (cfg)
  );

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [NR*8-1:0] pack_exp();
    logic [NR*8-1:0] v;
    for (int k = 0; k < NR; k++) v[8*k +: 8] = exp_r[k];
    return v;
  endfunction

  task automatic set_defaults();
    exp_r[0] = 8'hF0; exp_r[1] = 8'hEF; exp_r[2] = 8'h7F; exp_r[3] = 8'hFF;
    exp_r[4] = 8'h0F; exp_r[5] = 8'h13; exp_r[6] = 8'h00;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0;
    end
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    s1 = sda_line; wq();
    s2 = sda_line;
    scl = 1'b0; wq();
    ack = ~s1;
    if (s1 != s2) glitch = 1'b1;
  endtask

  task automatic xfer(input int n, input bit do_stop);
    logic a;
    bus_start();
    for (int i = 0; i < n; i++) begin
      send_byte(tx[i], a);
      acks[i] = a;
    end
    if (do_stop) bus_stop();
  endtask

  task automatic check_cfg(input string tag);
    check(cfg === pack_exp(), tag, 64'(cfg), 64'(pack_exp()));
  endtask

  task automatic t_reset();
    set_defaults();
    check_cfg("R1 defaults after reset");
    check(cfg[1:0] == 2'b00 && cfg[3] == 1'b0 && cfg[7:4] == 4'hF,
          "R1 reg0 fields", 64'(cfg[7:0]), 64'hF0);
    check(sda_oe == 1'b0, "R3 idle no drive", 64'(sda_oe), 64'd0);
  endtask

  task automatic t_full_write();
    tx[0] = 8'hD2; tx[1] = 8'h00; tx[2] = 8'h07;
    for (int i = 0; i < NR; i++) tx[3+i] = 8'(8'h11 * (i + 1));
    glitch = 1'b0;
    xfer(10, 1'b1);
    check(acks[0] == 1'b1, "R3 address acked", 64'(acks[0]), 64'd1);
    check(acks[1] && acks[2], "R4 skip bytes acked", 64'({acks[1], acks[2]}), 64'd3);
    for (int i = 0; i < NR; i++) begin
      check(acks[3+i] == 1'b1, "R5 data acked", 64'(i), 64'd1);
      exp_r[i] = tx[3+i];
    end
    check_cfg("R5 full write order");
    check(glitch == 1'b0, "R8 ack stable while SCL high", 64'(glitch), 64'd0);
  endtask

  task automatic t_partial();
    tx[0] = 8'hD2; tx[1] = 8'hAA; tx[2] = 8'hBB; tx[3] = 8'hA5; tx[4] = 8'h5A;
    xfer(5, 1'b1);
    exp_r[0] = 8'hA5; exp_r[1] = 8'h5A;
    check(acks[3] && acks[4], "R5 partial acked", 64'({acks[3], acks[4]}), 64'd3);
    check_cfg("R5 partial keeps rest");
  endtask

  task automatic t_skip_only();
    tx[0] = 8'hD2; tx[1] = 8'h01; tx[2] = 8'h02;
    xfer(3, 1'b1);
    check(acks[1] && acks[2], "R4 don't-care acked", 64'({acks[1], acks[2]}), 64'd3);
    check_cfg("R4 don't-care not stored");
  endtask

  task automatic t_wrong_addr();
    tx[0] = 8'hD0; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h99;
    xfer(4, 1'b1);
    check(!acks[0] && !acks[1] && !acks[2] && !acks[3], "R6 wrong address silent",
          64'({acks[0], acks[1], acks[2], acks[3]}), 64'd0);
    check_cfg("R6 wrong address no write");
  endtask

  task automatic t_read_bit();
    tx[0] = 8'hD3; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h66;
    xfer(4, 1'b1);
    check(!acks[0] && !acks[3], "R6 read direction silent", 64'({acks[0], acks[3]}), 64'd0);
    check_cfg("R6 read direction no write");
  endtask

  task automatic t_overflow();
    tx[0] = 8'hD2; tx[1] = 8'h00; tx[2] = 8'h00;
    for (int i = 0; i < 9; i++) tx[3+i] = 8'(i + 1);
    xfer(12, 1'b1);
    check(acks[10] && acks[11], "R7 excess acked", 64'({acks[10], acks[11]}), 64'd3);
    for (int i = 0; i < NR; i++) exp_r[i] = 8'(i + 1);
    check_cfg("R7 excess discarded");
  endtask

  task automatic t_restart();
    tx[0] = 8'hD2; tx[1] = 8'h00;
    xfer(2, 1'b0);
    tx[0] = 8'hD2; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'hC3;
    xfer(4, 1'b1);
    check(acks[0] && acks[3], "R2 repeated START acked", 64'({acks[0], acks[3]}), 64'd3);
    exp_r[0] = 8'hC3;
    check_cfg("R2 repeated START restarts at reg0");
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    set_defaults();
    check_cfg("R1 defaults after second reset");
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_write();
    t_partial();
    t_skip_only();
    t_wrong_addr();
    t_read_bit();
    t_overflow();
    t_restart();
    t_reset_again();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule